// File: doc/BRIEF.md
# Extended-Range Tick Timestamp

This block keeps a free-running system timestamp. A down-counter of `LOW_W` bits (32 by default) sits below a small epoch counter. Together they span `TICKS_PER_US * 2^LOW_W` ticks, where `TICKS_PER_US` is the oscillator frequency in MHz divided by eight. With the default width the timestamp rolls over after exactly 2^32 microseconds.

The block reports the time as an up-counting tick value and as a microsecond value. It raises an interrupt flag each time the low counter passes zero and reloads. It also gives a single-cycle pulse when a full rollover has been retired.

The epoch register changes only when a pending underflow is retired. Retirement happens on an interrupt clear, or on a further underflow that arrives while the flag is still up. While the flag is pending, the read path uses the epoch corrected by one step. This keeps the reported count continuous whether or not software has serviced the interrupt yet.

Top module: `tstamp_counter`

## Requirements
- R1: During and after a synchronous reset, `up_ticks` is 0, `usec` is 0, and both `irq` and `wrap_pulse` are 0.
- R2: Each cycle with `tick_en` high raises `up_ticks` by exactly one, wrapping from `TICKS_PER_US*2^LOW_W-1` to 0. A cycle with `tick_en` low leaves `up_ticks` unchanged.
- R3: The low counter passes zero on every `2^LOW_W`-th enabled tick, which is when `up_ticks` becomes a multiple of `2^LOW_W`. That tick sets `irq`, and `up_ticks` keeps counting without a step while `irq` is pending.
- R4: A cycle with `irq_clr` high and no underflow drops `irq` in the next cycle and does not change `up_ticks`.
- R5: An underflow that arrives while `irq` is still pending keeps `irq` set and keeps `up_ticks` continuous.
- R6: An `irq_clr` that coincides with an underflow leaves `irq` set and keeps `up_ticks` continuous.
- R7: After `TICKS_PER_US*2^LOW_W` enabled ticks from reset, `up_ticks` reads 0 again, even while that underflow is still pending.
- R8: `wrap_pulse` is high for exactly one cycle, in the cycle after the edge that retires the pending underflow which ended the last epoch. It is low at all other times.
- R9: `usec` equals `up_ticks / TICKS_PER_US`, truncated to `LOW_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Advances the timestamp by one tick |
| irq_clr | input | 1 | Clears the underflow interrupt flag and retires the pending underflow |
| up_ticks | output | LOW_W+clog2(TICKS_PER_US) | Up-counting tick value |
| usec | output | LOW_W | Microsecond value |
| irq | output | 1 | Underflow interrupt flag |
| wrap_pulse | output | 1 | One-cycle pulse on a retired full rollover |

## Verification
A stale or doubly applied epoch step shows at `up_ticks` as a jump of exactly `2^LOW_W` ticks. It appears in the first cycle after the underflow or clear that caused it, so each of those cycles is checked against a simple tick count. A flag that fails to set or to drop shows at `irq` one cycle after the tick or clear. A wrong reload of the epoch on the last epoch shows at the rollover as a nonzero `up_ticks`, or as a missing or repeated `wrap_pulse`. The sequence is exercised through every ordering of clear and underflow.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;

   // Width of the epoch register for a given tick rate (rate >= 2).
   function automatic int epoch_width(input int ticks_per_us);
      return $clog2(ticks_per_us);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/tstamp_low_ctr.sv
module tstamp_low_ctr #(
   parameter int LOW_W = 32
) (
   input  logic             clk,
   input  logic             srst,
   input  logic             tick_en,
   output logic [LOW_W-1:0] low,
   output logic             uflow
);

   assign uflow = tick_en && (low == '0);

   always_ff @(posedge clk) begin
      if (srst)
         low <= '1;
      else if (tick_en)
         low <= low - 1'b1;   // '0 - 1 reloads all ones
   end

endmodule

// File: rtl/tstamp_epoch.sv
module tstamp_epoch #(
   parameter int TICKS_PER_US = 4,
   parameter int EP_W         = 2
) (
   input  logic            clk,
   input  logic            srst,
   input  logic            uflow,
   input  logic            clr,
   output logic [EP_W-1:0] epoch,
   output logic            pend,
   output logic            wrap
);

   localparam logic [EP_W-1:0] EP_TOP = EP_W'(TICKS_PER_US - 1);

   logic retire;
   assign retire = pend && (clr || uflow);

   always_ff @(posedge clk) begin
      if (srst) begin
         epoch <= EP_TOP;
         pend  <= 1'b0;
         wrap  <= 1'b0;
      end else begin
         wrap <= retire && (epoch == '0);
         if (retire)
            epoch <= (epoch == '0) ? EP_TOP : epoch - 1'b1;
         pend <= uflow || (pend && !clr);
      end
   end

   p_irq_set_r3 : assert property (@(posedge clk) disable iff (srst)
      uflow |=> pend);

   p_irq_drop_r4 : assert property (@(posedge clk) disable iff (srst)
      (pend && clr && !uflow) |=> !pend);

   p_wrap_single_r8 : assert property (@(posedge clk) disable iff (srst)
      wrap |=> !wrap);

endmodule

// File: rtl/tstamp_scale.sv
module tstamp_scale #(
   parameter int TICKS_PER_US = 4,
   parameter int LOW_W        = 32,
   parameter int EP_W         = 2,
   parameter int UP_W         = LOW_W + EP_W
) (
   input  logic [EP_W-1:0]  epoch,
   input  logic             pend,
   input  logic [LOW_W-1:0] low,
   output logic [UP_W-1:0]  up,
   output logic [LOW_W-1:0] usec
);

   localparam logic [EP_W-1:0] EP_TOP  = EP_W'(TICKS_PER_US - 1);
   localparam logic [UP_W:0]   OVF_EXT = ((UP_W+1)'(TICKS_PER_US) << LOW_W) - 1'b1;
   localparam logic [UP_W-1:0] OVF     = OVF_EXT[UP_W-1:0];

   logic [EP_W-1:0] ep_eff;

   // A pending underflow has not yet been folded into the epoch.
   always_comb begin
      ep_eff = epoch;
      if (pend)
         ep_eff = (epoch == '0) ? EP_TOP : epoch - 1'b1;
   end

   assign up = OVF - {ep_eff, low};

   generate
      if (tstamp_pkg::is_pow2(TICKS_PER_US)) begin : g_shift
         logic [UP_W-1:0] q;
         assign q    = up >> EP_W;
         assign usec = q[LOW_W-1:0];
      end else begin : g_div
         logic [UP_W-1:0] q;
         assign q    = up / UP_W'(TICKS_PER_US);
         assign usec = q[LOW_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
   parameter int OSC_MHZ = 32,
   parameter int LOW_W   = 32
) (
   input  logic                                     clk,
   input  logic                                     srst,
   input  logic                                     tick_en,
   input  logic                                     irq_clr,
   output logic [LOW_W+$clog2(OSC_MHZ/8)-1:0]       up_ticks,
   output logic [LOW_W-1:0]                         usec,
   output logic                                     irq,
   output logic                                     wrap_pulse
);

   localparam int TICKS_PER_US = OSC_MHZ / 8;
   localparam int EP_W         = tstamp_pkg::epoch_width(TICKS_PER_US);
   localparam int UP_W         = LOW_W + EP_W;
   localparam logic [UP_W:0]   OVF_EXT = ((UP_W+1)'(TICKS_PER_US) << LOW_W) - 1'b1;
   localparam logic [UP_W-1:0] UP_MAX  = OVF_EXT[UP_W-1:0];

   generate
      if (OSC_MHZ % 8 != 0) begin : g_bad_osc
         $error("OSC_MHZ must be a multiple of 8");
      end
      if (TICKS_PER_US < 2) begin : g_bad_rate
         $error("OSC_MHZ/8 must be at least 2");
      end
      if (LOW_W < 2 || LOW_W > 32) begin : g_bad_width
         $error("LOW_W must lie in 2..32");
      end
   endgenerate

   logic [LOW_W-1:0] low;
   logic             uflow;
   logic [EP_W-1:0]  epoch;

   tstamp_low_ctr #(.LOW_W(LOW_W)) u_low (
      .clk     (clk),
      .srst    (srst),
      .tick_en (tick_en),
      .low     (low),
      .uflow   (uflow)
   );

   tstamp_epoch #(.TICKS_PER_US(TICKS_PER_US), .EP_W(EP_W)) u_epoch (
      .clk   (clk),
      .srst  (srst),
      .uflow (uflow),
      .clr   (irq_clr),
      .epoch (epoch),
      .pend  (irq),
      .wrap  (wrap_pulse)
   );

   tstamp_scale #(
      .TICKS_PER_US(TICKS_PER_US), .LOW_W(LOW_W), .EP_W(EP_W), .UP_W(UP_W)
   ) u_scale (
      .epoch (epoch),
      .pend  (irq),
      .low   (low),
      .up    (up_ticks),
      .usec  (usec)
   );

   p_step_r2 : assert property (@(posedge clk) disable iff (srst)
      tick_en |=> ((up_ticks == UP_W'($past(up_ticks) + 1'b1)) && ($past(up_ticks) != UP_MAX))
                  || (($past(up_ticks) == UP_MAX) && (up_ticks == '0)));

   p_hold_r4 : assert property (@(posedge clk) disable iff (srst)
      !tick_en |=> $stable(up_ticks));

endmodule

// File: tb/tstamp_counter_tb.sv
module tstamp_counter_tb;

   localparam int CLK_P   = 10;
   localparam int OSC     = 32;   // four ticks per microsecond
   localparam int LW      = 4;
   localparam int TPU     = OSC / 8;
   localparam int SPAN    = TPU << LW;   // 64 ticks per rollover

   logic       clk = 1'b0;
   logic       srst, tick_en, irq_clr;
   logic [5:0] up_ticks;
   logic [3:0] usec;
   logic       irq, wrap_pulse;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   tstamp_counter #(.OSC_MHZ(OSC), .LOW_W(LW)) u_dut (
      .clk        (clk),
      .srst       (srst),
      .tick_en    (tick_en),
      .irq_clr    (irq_clr),
      .up_ticks   (up_ticks),
      .usec       (usec),
      .irq        (irq),
      .wrap_pulse (wrap_pulse)
   );

   typedef struct packed {
      logic [7:0] n;
      logic       tk;
      logic       cl;
      logic [5:0] up;
      logic       irq;
   } vec_t;

   // Hold tk/cl for n cycles, then expect up and irq.
   localparam vec_t TBL [9] = '{
      '{8'd15, 1'b1, 1'b0, 6'd15, 1'b0},   // R2 plain counting
      '{8'd1,  1'b1, 1'b0, 6'd16, 1'b1},   // R3 underflow, pending
      '{8'd3,  1'b0, 1'b0, 6'd16, 1'b1},   // R2 hold while idle
      '{8'd1,  1'b0, 1'b1, 6'd16, 1'b0},   // R4 clear keeps count
      '{8'd16, 1'b1, 1'b0, 6'd32, 1'b1},   // R3 second underflow
      '{8'd16, 1'b1, 1'b0, 6'd48, 1'b1},   // R5 underflow while pending
      '{8'd1,  1'b1, 1'b1, 6'd49, 1'b0},   // R4 clear during tick
      '{8'd14, 1'b1, 1'b0, 6'd63, 1'b0},   // R2 top of range
      '{8'd1,  1'b1, 1'b0, 6'd0,  1'b1}    // R7 rollover while pending
   };

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic tk, input logic cl);
      @(negedge clk);
      tick_en = tk;
      irq_clr = cl;
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic do_reset();
      @(negedge clk);
      srst = 1'b1; tick_en = 1'b0; irq_clr = 1'b0;
      @(posedge clk); @(posedge clk);
      #(CLK_P/4);
      check("R1 up", int'(up_ticks), 0);
      check("R1 usec", int'(usec), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 wrap", int'(wrap_pulse), 0);
      @(negedge clk);
      srst = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] lfsr;
      int         m_up;
      logic       m_irq;
      int         wraps;

      srst = 1'b1; tick_en = 1'b0; irq_clr = 1'b0;
      do_reset();

      foreach (TBL[i]) begin
         for (int k = 0; k < int'(TBL[i].n); k++) step(TBL[i].tk, TBL[i].cl);
         check("R2/R3/R4 up", int'(up_ticks), int'(TBL[i].up));
         check("R3/R4 irq", int'(irq), int'(TBL[i].irq));
         check("R9 usec", int'(usec), int'(TBL[i].up) / TPU);
      end

      // R8: clearing the pending rollover gives one wrap pulse
      check("R8 no early wrap", int'(wrap_pulse), 0);
      step(1'b0, 1'b1);
      check("R8 wrap high", int'(wrap_pulse), 1);
      check("R7 up after retire", int'(up_ticks), 0);
      check("R4 irq dropped", int'(irq), 0);
      step(1'b0, 1'b0);
      check("R8 wrap single", int'(wrap_pulse), 0);

      // R6: clear coinciding with an underflow
      for (int k = 0; k < 16; k++) step(1'b1, 1'b0);
      for (int k = 0; k < 15; k++) step(1'b1, 1'b0);
      check("R6 before", int'(up_ticks), 31);
      step(1'b1, 1'b1);
      check("R6 up", int'(up_ticks), 32);
      check("R6 irq kept", int'(irq), 1);
      step(1'b0, 1'b1);
      check("R6 up after clear", int'(up_ticks), 32);
      check("R6 irq cleared", int'(irq), 0);

      // R1: reset in mid-run
      do_reset();

      // Free run with pseudo-random ticks and clears, against a tick model
      lfsr = 8'hA5; m_up = 0; m_irq = 1'b0; wraps = 0;
      for (int c = 0; c < 600; c++) begin
         logic tk, cl, uf;
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         tk = lfsr[0] | lfsr[1];
         cl = lfsr[2] & lfsr[5] & lfsr[6];
         uf = tk && ((m_up % 16) == 15);
         step(tk, cl);
         if (tk) m_up = (m_up + 1) % SPAN;
         m_irq = uf | (m_irq & ~cl);
         if (wrap_pulse) wraps++;
         if (up_ticks != 6'(m_up) || irq != m_irq || usec != 4'(m_up / TPU)) begin
            check("R2/R3/R5/R9 free run up", int'(up_ticks), m_up);
            check("R3/R4 free run irq", int'(irq), int'(m_irq));
            check("R9 free run usec", int'(usec), m_up / TPU);
         end
      end
      check("R2 free run final", int'(up_ticks), m_up);
      check("R8 wraps seen", int'(wraps > 0), 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule